// File: doc/BRIEF.md
# Per-Task Banked Scratch Register File

This block holds a set of scratch registers arranged as several banks of 32 words each. Every one of 16 microtasks owns a private bank pointer, so two tasks that use the same register number reach different storage whenever their pointers differ. The block sits on a shared wired-AND data bus. It can only pull bus bits low, so everything it offers the bus is an AND-mask, and an all-ones mask means it has no effect on the bus.

Each cycle is split into an early and a late half. A read offers, in the early half, the selected word of the active task's bank. Register select 0 is the exception: it offers the memory-data latch M instead, which means the word stored at index 0 can never be read back. A load drives an all-zero mask in the early half and writes M into the selected register at the end of the cycle. A bank-pointer load takes a 3-bit field from the late bus value, reduces it modulo the bank count, and stores the result as the active task's pointer. Scheduling of tasks and the arbitration of the other bus drivers are handled elsewhere.

Top module: `scratch_regfile_banked`

## Requirements
- R1: With neither `rd_en` nor `ld_en` asserted, `bus_mask` is all ones.
- R2: With `rd_en` high, `ld_en` low and `rsel` not 0, `bus_mask` equals the word at index `rsel` of the bank selected by the current pointer of task `task_id`, in the same cycle.
- R3: With `rd_en` high, `ld_en` low and `rsel` equal to 0, `bus_mask` equals `m_in`, whatever is stored at index 0.
- R4: While `ld_en` is high, `bus_mask` is all zeros, whether or not `rd_en` is also high.
- R5: A cycle with `ld_en` high writes `m_in` into index `rsel` of the active task's bank at the clock edge ending that cycle. The new value is readable from the next cycle on.
- R6: A cycle with `bank_ld_en` high sets the pointer of task `task_id` to `bus_late[3:1]` (bit 3 is the most significant) modulo NUM_BANKS (default 6, so field values 6 and 7 select banks 0 and 1). The new pointer takes effect from the next cycle on.
- R7: Loading one task's pointer, or writing through it, leaves the pointers of all other tasks unchanged, and with it what those tasks read.
- R8: After reset, every bank pointer is 0 and every stored word is 0.
- R9: In a cycle that also loads the bank pointer, a read and a write both use the pointer value from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the late-phase updates happen at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_id | input | 4 | Number of the active microtask |
| rsel | input | 5 | Register select field |
| rd_en | input | 1 | Read strobe, early phase |
| ld_en | input | 1 | Register load strobe |
| bank_ld_en | input | 1 | Bank-pointer load strobe, late phase |
| m_in | input | 16 | Memory-data latch value |
| bus_late | input | 16 | Bus value seen in the late phase |
| bus_mask | output | 16 | AND-mask this block offers to the wired-AND bus |

## Verification
The assertions take for granted that every strobe, `task_id`, `rsel`, `m_in` and `bus_late` hold known values for a whole cycle, and that reset is applied before the first strobe. The cross-cycle properties also assume that a read of freshly written data or of a new pointer comes from the same task that did the write. The bench meets this by changing inputs only shortly after a rising edge, by starting in reset with every input at zero, and by passing only defined values, including in its random phase. Where a property needs the same task in two cycles, it makes the check conditional on that and does not restrict the stimulus.

// File: rtl/scratch_rf_pkg.sv
package scratch_rf_pkg;

  localparam int FIELD_LSB = 1;
  localparam int FIELD_W   = 3;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_LATCH = 2'd1,
    SRC_WORD = 2'd2,
    SRC_CLEAR = 2'd3
  } mask_src_e;

  function automatic int unsigned fold_bank(logic [FIELD_W-1:0] field,
                                            int unsigned nbanks);
    return {{(32-FIELD_W){1'b0}}, field} % nbanks;
  endfunction

  function automatic mask_src_e pick_source(logic rd, logic ld, logic sel_zero);
    if (ld) return SRC_CLEAR;
    if (!rd) return SRC_IDLE;
    if (sel_zero) return SRC_LATCH;
    return SRC_WORD;
  endfunction

endpackage

// File: rtl/scratch_bank_ptrs.sv
module scratch_bank_ptrs
  import scratch_rf_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int NUM_BANKS = 6,
  parameter int TASK_W    = 4,
  parameter int BANK_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TASK_W-1:0]   task_id,
  input  logic                load_en,
  input  logic [FIELD_W-1:0]  field,
  output logic [BANK_W-1:0]   cur_bank
);

  logic [BANK_W-1:0] ptr_q [NUM_TASKS];
  logic [BANK_W-1:0] next_ptr;

  assign next_ptr = BANK_W'(fold_bank(field, NUM_BANKS));

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    logic hit;
    assign hit = load_en && (task_id == TASK_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr_q[t] <= '0;
      else if (hit) ptr_q[t] <= next_ptr;
    end
  end

  assign cur_bank = ptr_q[task_id];

endmodule

// File: rtl/scratch_store.sv
module scratch_store #(
  parameter int NUM_BANKS = 6,
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 3,
  parameter int SEL_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_q [NUM_BANKS][NUM_REGS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = wr_en && (bank == BANK_W'(b));
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          word_q[b][r] <= '0;
        else if (bank_hit && (addr == SEL_W'(r)))
          word_q[b][r] <= wr_data;
      end
    end
  end

  assign rd_data = word_q[bank][addr];

endmodule

// File: rtl/scratch_bus_mask.sv
module scratch_bus_mask
  import scratch_rf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 5
) (
  input  logic              rd_en,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  rsel,
  input  logic [DATA_W-1:0] m_in,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] mask
);

  mask_src_e src;

  assign src = pick_source(rd_en, ld_en, rsel == '0);

  always_comb begin
    unique case (src)
      SRC_CLEAR: mask = '0;
      SRC_LATCH: mask = m_in;
      SRC_WORD:  mask = word;
      default:   mask = '1;
    endcase
  end

endmodule

// File: rtl/scratch_regfile_banked.sv
module scratch_regfile_banked
  import scratch_rf_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int NUM_BANKS = 6,
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 16,
  localparam int TASK_W   = $clog2(NUM_TASKS),
  localparam int SEL_W    = $clog2(NUM_REGS),
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TASK_W-1:0] task_id,
  input  logic [SEL_W-1:0]  rsel,
  input  logic              rd_en,
  input  logic              ld_en,
  input  logic              bank_ld_en,
  input  logic [DATA_W-1:0] m_in,
  input  logic [DATA_W-1:0] bus_late,
  output logic [DATA_W-1:0] bus_mask
);

  logic [BANK_W-1:0]  cur_bank;
  logic [FIELD_W-1:0] bank_field;
  logic [DATA_W-1:0]  rd_word;
  logic               wr_fire;

  assign bank_field = bus_late[FIELD_LSB +: FIELD_W];
  assign wr_fire    = ld_en;

  scratch_bank_ptrs #(
    .NUM_TASKS(NUM_TASKS), .NUM_BANKS(NUM_BANKS),
    .TASK_W(TASK_W), .BANK_W(BANK_W)
  ) u_ptrs (
    .clk(clk), .rst_n(rst_n), .task_id(task_id),
    .load_en(bank_ld_en), .field(bank_field), .cur_bank(cur_bank)
  );

  scratch_store #(
    .NUM_BANKS(NUM_BANKS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
    .BANK_W(BANK_W), .SEL_W(SEL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .bank(cur_bank),
    .addr(rsel), .wr_data(m_in), .rd_data(rd_word)
  );

  scratch_bus_mask #(
    .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_mask (
    .rd_en(rd_en), .ld_en(ld_en), .rsel(rsel), .m_in(m_in),
    .word(rd_word), .mask(bus_mask)
  );

endmodule

// File: rtl/scratch_regfile_chk.sv
module scratch_regfile_chk
  import scratch_rf_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int DATA_W    = 16,
  parameter int TASK_W    = 4,
  parameter int SEL_W     = 5,
  parameter int BANK_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TASK_W-1:0] task_id,
  input logic [SEL_W-1:0]  rsel,
  input logic              rd_en,
  input logic              ld_en,
  input logic              bank_ld_en,
  input logic [DATA_W-1:0] m_in,
  input logic [DATA_W-1:0] bus_late,
  input logic [DATA_W-1:0] bus_mask,
  input logic [BANK_W-1:0] cur_bank,
  input logic              wr_fire
);

  a_r1_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !ld_en) |-> bus_mask == '1);

  a_r3_sel0_gives_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ld_en && rsel == '0) |-> bus_mask == m_in);

  a_r4_load_clears_bus: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> bus_mask == '0);

  a_r5_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rsel != '0 && !bank_ld_en) |=>
      (!rd_en || ld_en || task_id != $past(task_id) || rsel != $past(rsel)
       || bus_mask == $past(m_in)));

  a_r6_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_bank) < NUM_BANKS);

  a_r6_bank_folded: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld_en |=> (task_id != $past(task_id)) ||
      (int'(cur_bank) == int'(fold_bank($past(bus_late[FIELD_LSB +: FIELD_W]),
                                         NUM_BANKS))));

  a_r7_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ld_en |=> (task_id != $past(task_id)) || $stable(cur_bank));

endmodule

bind scratch_regfile_banked scratch_regfile_chk #(
  .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .TASK_W(TASK_W),
  .SEL_W(SEL_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .task_id(task_id), .rsel(rsel),
  .rd_en(rd_en), .ld_en(ld_en), .bank_ld_en(bank_ld_en), .m_in(m_in),
  .bus_late(bus_late), .bus_mask(bus_mask), .cur_bank(cur_bank),
  .wr_fire(wr_fire)
);

// File: tb/tb_scratch_regfile_banked.sv
module tb_scratch_regfile_banked;

  localparam int NB = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  task_id = '0;
  logic [4:0]  rsel = '0;
  logic        rd_en = 1'b0, ld_en = 1'b0, bank_ld_en = 1'b0;
  logic [15:0] m_in = '0, bus_late = '0;
  logic [15:0] bus_mask;

  int checks = 0;
  int errors = 0;

  int model_mem [NB][32];
  int model_ptr [16];

  always #5 clk = ~clk;

  scratch_regfile_banked dut (
    .clk(clk), .rst_n(rst_n), .task_id(task_id), .rsel(rsel),
    .rd_en(rd_en), .ld_en(ld_en), .bank_ld_en(bank_ld_en),
    .m_in(m_in), .bus_late(bus_late), .bus_mask(bus_mask)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    summary();
    $finish;
  end

  // One bus cycle: drive after the edge, compare mid-cycle, then advance model.
  task automatic cyc(int t, int s, bit rd, bit ld, bit bl, int m, int bus,
                     string tag);
    int exp_mask;
    int bank;
    @(posedge clk);
    #1;
    task_id = 4'(t); rsel = 5'(s); rd_en = rd; ld_en = ld; bank_ld_en = bl;
    m_in = 16'(m); bus_late = 16'(bus);
    #4;
    bank = model_ptr[t];
    exp_mask = 'hFFFF;
    if (rd) exp_mask = (s == 0) ? (m & 'hFFFF) : model_mem[bank][s];
    if (ld) exp_mask = 0;
    checks++;
    if (int'(bus_mask) != exp_mask) begin
      errors++;
      $display("FAIL %s: task %0d sel %0d rd %0b ld %0b actual %h expected %h",
               tag, t, s, rd, ld, bus_mask, 16'(exp_mask));
    end
    if (ld) model_mem[bank][s] = m & 'hFFFF;
    if (bl) model_ptr[t] = ((bus >> 1) & 7) % NB;
  endtask

  task automatic idle_drive();
    @(posedge clk);
    #1;
    rd_en = 0; ld_en = 0; bank_ld_en = 0;
  endtask

  initial begin
    foreach (model_mem[b, r]) model_mem[b][r] = 0;
    foreach (model_ptr[t]) model_ptr[t] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: everything starts at zero
    for (int s = 1; s < 32; s++) cyc(0, s, 1, 0, 0, 'h5A5A, 0, "R8");
    for (int s = 1; s < 32; s += 7) cyc(9, s, 1, 0, 0, 0, 0, "R8");

    // R1: idle leaves the bus alone
    cyc(1, 4, 0, 0, 0, 'h0000, 'hFFFF, "R1");
    cyc(2, 0, 0, 0, 0, 'h1234, 'h0000, "R1");

    // R3: select 0 returns M even after index 0 is written
    cyc(0, 0, 0, 1, 0, 'hBEEF, 0, "R4");
    cyc(0, 0, 1, 0, 0, 'h0F0F, 0, "R3");
    cyc(0, 0, 1, 0, 0, 'hC3A5, 0, "R3");

    // R4 and R5: load clears bus, then value visible
    cyc(0, 3, 1, 1, 0, 'h1234, 0, "R4");
    cyc(0, 3, 1, 0, 0, 'h0000, 0, "R5");
    cyc(0, 31, 0, 1, 0, 'hFFFF, 0, "R4");
    cyc(0, 31, 1, 0, 0, 'h0000, 0, "R5");

    // R6: every field value, folded modulo the bank count
    for (int f = 0; f < 8; f++) begin
      cyc(2, 7, 0, 0, 1, 0, (f << 1) | 'hFFF1 & ~'h000E, "R6");
      cyc(2, 7, 0, 1, 0, 'hA000 + f, 0, "R6");
      cyc(2, 7, 1, 0, 0, 0, 0, "R6");
    end
    for (int f = 0; f < 8; f++) begin
      cyc(2, 7, 0, 0, 1, 0, f << 1, "R6");
      cyc(2, 7, 1, 0, 0, 0, 0, "R6");
    end

    // R7: task pointers are private
    cyc(3, 0, 0, 0, 1, 0, 2 << 1, "R7");
    cyc(3, 9, 0, 1, 0, 'h7777, 0, "R7");
    cyc(4, 9, 1, 0, 0, 0, 0, "R7");
    cyc(3, 9, 1, 0, 0, 0, 0, "R7");
    cyc(4, 9, 0, 1, 0, 'h1111, 0, "R7");
    cyc(3, 9, 1, 0, 0, 0, 0, "R7");
    cyc(2, 9, 1, 0, 0, 0, 0, "R7");

    // R9: same-cycle pointer load uses the old bank
    cyc(5, 12, 0, 1, 0, 'h0C0C, 0, "R9");
    cyc(5, 12, 1, 0, 1, 0, 4 << 1, "R9");
    cyc(5, 12, 1, 0, 0, 0, 0, "R9");
    cyc(5, 13, 0, 1, 1, 'hD00D, 1 << 1, "R9");
    cyc(5, 13, 1, 0, 0, 0, 0, "R9");
    cyc(5, 13, 1, 0, 1, 0, 4 << 1, "R9");
    cyc(5, 13, 1, 0, 0, 0, 0, "R9");

    // Random mix of all operations
    for (int i = 0; i < 600; i++) begin
      int t, s, m, bus;
      bit rd, ld, bl;
      t = $urandom_range(0, 15);
      s = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 31);
      rd = $urandom_range(0, 1);
      ld = ($urandom_range(0, 3) == 0);
      bl = ($urandom_range(0, 4) == 0);
      m = $urandom_range(0, 'hFFFF);
      bus = $urandom_range(0, 'hFFFF);
      cyc(t, s, rd, ld, bl, m, bus,
          ld ? "R4" : (!rd ? "R1" : (s == 0 ? "R3" : "R2")));
    end

    idle_drive();
    summary();
    $finish;
  end

endmodule